// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a big-endian processor port and a peripheral register window in which every aligned 4-byte group holds registers of one native width. That width is 1, 2 or 4 bytes, or the group is empty. The processor issues byte, halfword or word requests. The adapter looks up the native width of the addressed group and turns each request into the native accesses the registers expect:

- A request wider than the registers is split into several narrower accesses, issued in ascending address order.
- A request that matches the native width passes through as a single access.
- A read narrower than the register reads the whole register and returns only the addressed lanes.
- A write narrower than the register reads the register, merges the new bytes into the addressed lanes, and writes the result back.

Both sides use a valid/ready handshake. On the processor side, `cpu_valid` and every request field stay stable until `cpu_ready` is high at a clock edge. `cpu_ready` is a single-cycle completion strobe that carries `cpu_rdata` and `cpu_err`. On the register side, the adapter holds `reg_valid` and all of its fields stable until `reg_ready` is sampled high. Read data is taken from `reg_rdata` in that same cycle. The register side may stall for any number of cycles. Only one native access is outstanding at a time.

Top module: `mwa_adapter`

## Requirements
- R1: Only the low 10 bits of `cpu_addr` form the register offset. Higher address bits have no effect on the result.
- R2: A request is rejected with `cpu_err`=1, `cpu_rdata`=0 and no native access in either of two cases: any byte it covers lies above offset 0x200, or `cpu_size` is 3. Size codes are 0 for byte, 1 for halfword and 2 for word; `reg_size` uses the same codes.
- R3: The native width of the group at offset bits 9:2 (g) is set as follows:
  - g < 12: byte.
  - 12..15: halfword.
  - 16..47: word when g mod 3 = 2, otherwise halfword.
  - 48..63: empty.
  - 64..128: byte.

  A request to an empty group is rejected as in R2.
- R4: A byte read of a halfword or word register makes one native read of the whole aligned register and returns the addressed byte with big-endian lane order: offset 0 in the register is its most significant byte.
- R5: A halfword read of a word register makes one native word read and returns the upper half when offset bit 1 is 0, otherwise the lower half.
- R6: A halfword request to a byte group becomes two byte accesses, at the lower address first. The lower address carries data bits 15:8 and the higher address carries bits 7:0.
- R7: A word request to a halfword group becomes two halfword accesses, and to a byte group four byte accesses. All are issued in ascending address order, and the lowest address carries the most significant data.
- R8: A write narrower than its register reads the aligned register, replaces only the addressed bytes, and then writes the whole register back. These are two native accesses: read first, then write.
- R9: Every native access uses the native width of its group and is aligned to it. A request that matches the native width makes exactly one native access.
- R10: The adapter holds each native request stable until `reg_ready`. It raises `cpu_ready` for exactly one cycle, in the cycle right after the last native handshake.
- R11: A halfword request ignores address bit 0, and a word request ignores address bits 1:0.
- R12: During and directly after reset, `cpu_ready` and `reg_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request complete; response fields valid |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_rdata | output | 32 | Read data, right-justified |
| cpu_err | output | 1 | Request rejected |
| reg_valid | output | 1 | Native access request |
| reg_ready | input | 1 | Native access accepted / read data valid |
| reg_write | output | 1 | Native access is a write |
| reg_size | output | 2 | Native access size code |
| reg_addr | output | OFS_W | Native access offset |
| reg_wdata | output | 32 | Native write data, right-justified |
| reg_rdata | input | 32 | Native read data, right-justified |

## Verification
The hardest situation to reach is a read-modify-write, or a four-part split, in which the register side stalls between sub-accesses. In that case the adapter must keep the merge data and sub-access index intact across idle cycles. The bench's register model drops `reg_ready` one cycle in three on a free-running count. Because each request takes a different number of cycles, the stalls fall on different sub-access phases over the run. A native access log, together with the cycle of the last handshake, lets the bench check order, kind and data of each part and the completion latency.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

  localparam int DW = 32;

  // width codes held per 4-byte group
  localparam logic [1:0] WC_NONE = 2'd0;
  localparam logic [1:0] WC_BYTE = 2'd1;
  localparam logic [1:0] WC_HALF = 2'd2;
  localparam logic [1:0] WC_WORD = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUS   = 2'd1,
    ST_MERGE = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  // native width map, one entry per 4-byte group
  function automatic logic [1:0] group_width(input int unsigned g);
    if (g < 12)        return WC_BYTE;
    else if (g < 16)   return WC_HALF;
    else if (g < 48)   return ((g % 3) == 2) ? WC_WORD : WC_HALF;
    else if (g < 64)   return WC_NONE;
    else if (g <= 128) return WC_BYTE;
    else               return WC_NONE;
  endfunction

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/mwa_width_lut.sv
module mwa_width_lut
  import mwa_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic [OFS_W-1:0] ofs,
  output logic [1:0]       code
);
  localparam int GRP_W = OFS_W - 2;

  logic [GRP_W-1:0] grp;

  always_comb begin
    grp  = ofs[OFS_W-1:2];
    code = group_width(int'(grp));
  end
endmodule

// File: rtl/mwa_lane.sv
module mwa_lane
  import mwa_pkg::*;
(
  input  logic [1:0]    sz,
  input  logic [1:0]    wsz,
  input  logic [1:0]    boff,
  input  logic [1:0]    idx,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] piece_wd,
  output logic [DW-1:0] merged_wd,
  output logic [DW-1:0] narrow_rd,
  output logic [DW-1:0] acc_next
);
  localparam int NB = DW / 8;

  logic [DW-1:0] smask, wmask, placed;
  logic [1:0]    last, rem;
  logic [5:0]    psh, nsh;
  logic [2:0]    wb, sb, bo, gap;
  logic [7:0]    be_wide;
  logic [NB-1:0] be;

  always_comb begin
    smask    = size_mask(sz);
    wmask    = size_mask(wsz);
    last     = (sz > wsz) ? 2'((3'd1 << (sz - wsz)) - 3'd1) : 2'd0;
    rem      = last - idx;
    psh      = {4'd0, rem} << (3'd3 + {1'b0, wsz});
    piece_wd = (wdata >> psh) & wmask;
    wb       = 3'd1 << wsz;
    sb       = 3'd1 << sz;
    bo       = {1'b0, boff & 2'(wb - 3'd1)};
    gap      = (sb < wb) ? (wb - bo - sb) : 3'd0;
    nsh      = {gap, 3'b000};
    narrow_rd = (acc >> nsh) & smask;
    placed   = (wdata & smask) << nsh;
    be_wide  = ((8'd1 << sb) - 8'd1) << gap;
    be       = be_wide[NB-1:0];
    acc_next = (acc << {wb, 3'b000}) | (rdata & wmask);
  end

  // byte-lane merge for read-modify-write
  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign merged_wd[8*k +: 8] = be[k] ? placed[8*k +: 8] : acc[8*k +: 8];
  end
endmodule

// File: rtl/mwa_seq.sv
module mwa_seq
  import mwa_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int LIMIT = 'h200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [1:0]       cpu_size,
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       wcode,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_ready,
  output logic             cpu_err,
  output logic [DW-1:0]    cpu_rdata,
  output logic             reg_valid,
  input  logic             reg_ready,
  output logic             reg_write,
  output logic [1:0]       reg_size,
  output logic [OFS_W-1:0] reg_addr,
  output logic [DW-1:0]    reg_wdata,
  input  logic [DW-1:0]    reg_rdata,
  input  logic [DW-1:0]    piece_wd,
  input  logic [DW-1:0]    merged_wd,
  input  logic [DW-1:0]    narrow_rd,
  input  logic [DW-1:0]    acc_next,
  output logic [1:0]       r_sz,
  output logic [1:0]       r_wsz,
  output logic [1:0]       r_boff,
  output logic [1:0]       r_idx,
  output logic [DW-1:0]    r_wdata,
  output logic [DW-1:0]    r_acc
);
  localparam int EW = OFS_W + 1;

  seq_state_t       st;
  logic             r_write, r_err;
  logic [OFS_W-1:0] r_base;
  logic [OFS_W-1:0] base_in, step, aligned;
  logic [EW-1:0]    span_end;
  logic [1:0]       span_m1, last;
  logic             bad, split, narrow;

  // request decode at acceptance
  always_comb begin
    case (cpu_size)
      2'd0:    begin base_in = ofs;                        span_m1 = 2'd0; end
      2'd1:    begin base_in = {ofs[OFS_W-1:1], 1'b0};     span_m1 = 2'd1; end
      default: begin base_in = {ofs[OFS_W-1:2], 2'b00};    span_m1 = 2'd3; end
    endcase
    span_end = {1'b0, base_in} + EW'(span_m1);
    bad      = (cpu_size == 2'd3) || (wcode == WC_NONE) || (span_end > EW'(LIMIT));
  end

  // native address generation
  always_comb begin
    split  = r_sz > r_wsz;
    narrow = r_sz < r_wsz;
    last   = split ? 2'((3'd1 << (r_sz - r_wsz)) - 3'd1) : 2'd0;
    step   = OFS_W'(r_idx) << r_wsz;
    case (r_wsz)
      2'd0:    aligned = r_base;
      2'd1:    aligned = {r_base[OFS_W-1:1], 1'b0};
      default: aligned = {r_base[OFS_W-1:2], 2'b00};
    endcase
  end

  assign r_boff    = r_base[1:0];
  assign reg_valid = (st == ST_BUS) || (st == ST_MERGE);
  assign reg_size  = r_wsz;
  assign reg_addr  = narrow ? aligned : (r_base + step);
  assign reg_write = (st == ST_MERGE) || (r_write && !narrow);
  assign reg_wdata = (st == ST_MERGE) ? merged_wd : piece_wd;
  assign cpu_ready = (st == ST_DONE);
  assign cpu_err   = (st == ST_DONE) && r_err;
  assign cpu_rdata = (r_err || r_write) ? '0 : (narrow ? narrow_rd : r_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      r_write <= 1'b0;
      r_err   <= 1'b0;
      r_sz    <= 2'd0;
      r_wsz   <= 2'd0;
      r_base  <= '0;
      r_idx   <= 2'd0;
      r_wdata <= '0;
      r_acc   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cpu_valid) begin
          r_write <= cpu_write;
          r_err   <= bad;
          r_sz    <= cpu_size;
          r_wsz   <= (wcode == WC_NONE) ? 2'd0 : (wcode - 2'd1);
          r_base  <= base_in;
          r_idx   <= 2'd0;
          r_wdata <= cpu_wdata & size_mask(cpu_size);
          r_acc   <= '0;
          st      <= bad ? ST_DONE : ST_BUS;
        end
        ST_BUS: if (reg_ready) begin
          if (narrow) begin
            r_acc <= reg_rdata;
            st    <= r_write ? ST_MERGE : ST_DONE;
          end else begin
            r_acc <= acc_next;
            if (r_idx == last) st <= ST_DONE;
            else r_idx <= r_idx + 2'd1;
          end
        end
        ST_MERGE: if (reg_ready) st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwa_adapter.sv
module mwa_adapter
  import mwa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 10,
  parameter int LIMIT  = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_err,
  output logic              reg_valid,
  input  logic              reg_ready,
  output logic              reg_write,
  output logic [1:0]        reg_size,
  output logic [OFS_W-1:0]  reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata
);
  logic [OFS_W-1:0] ofs;
  logic [1:0]       wcode;
  logic [1:0]       r_sz, r_wsz, r_boff, r_idx;
  logic [DW-1:0]    r_wdata, r_acc;
  logic [DW-1:0]    piece_wd, merged_wd, narrow_rd, acc_next;

  assign ofs = cpu_addr[OFS_W-1:0];

  mwa_width_lut #(.OFS_W(OFS_W)) u_lut (
    .ofs  (ofs),
    .code (wcode)
  );

  mwa_seq #(.OFS_W(OFS_W), .LIMIT(LIMIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_write (cpu_write),
    .cpu_size  (cpu_size),
    .ofs       (ofs),
    .wcode     (wcode),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .cpu_err   (cpu_err),
    .cpu_rdata (cpu_rdata),
    .reg_valid (reg_valid),
    .reg_ready (reg_ready),
    .reg_write (reg_write),
    .reg_size  (reg_size),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .piece_wd  (piece_wd),
    .merged_wd (merged_wd),
    .narrow_rd (narrow_rd),
    .acc_next  (acc_next),
    .r_sz      (r_sz),
    .r_wsz     (r_wsz),
    .r_boff    (r_boff),
    .r_idx     (r_idx),
    .r_wdata   (r_wdata),
    .r_acc     (r_acc)
  );

  mwa_lane u_lane (
    .sz        (r_sz),
    .wsz       (r_wsz),
    .boff      (r_boff),
    .idx       (r_idx),
    .wdata     (r_wdata),
    .acc       (r_acc),
    .rdata     (reg_rdata),
    .piece_wd  (piece_wd),
    .merged_wd (merged_wd),
    .narrow_rd (narrow_rd),
    .acc_next  (acc_next)
  );
endmodule

// File: rtl/mwa_adapter_chk.sv
module mwa_adapter_chk
  import mwa_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int LIMIT = 'h200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ready,
  input logic             cpu_err,
  input logic             reg_valid,
  input logic             reg_ready,
  input logic             reg_write,
  input logic [1:0]       reg_size,
  input logic [OFS_W-1:0] reg_addr,
  input logic [31:0]      reg_wdata
);
  logic [1:0] grp_code;
  logic [1:0] low_bits;
  always_comb begin
    grp_code = group_width(int'(reg_addr[OFS_W-1:2]));
    low_bits = reg_addr[1:0] & 2'((3'd1 << reg_size) - 3'd1);
  end

  assert_native_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> (grp_code != WC_NONE) && (reg_size == grp_code - 2'd1));

  assert_native_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> (low_bits == 2'd0));

  assert_native_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> (int'(reg_addr) <= LIMIT));

  assert_hold_native_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) && $stable(reg_write)
      && $stable(reg_size) && $stable(reg_wdata));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  assert_err_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_ready);

  assert_no_native_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !reg_valid);
endmodule

bind mwa_adapter mwa_adapter_chk #(.OFS_W(OFS_W), .LIMIT(LIMIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .cpu_err   (cpu_err),
  .reg_valid (reg_valid),
  .reg_ready (reg_ready),
  .reg_write (reg_write),
  .reg_size  (reg_size),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/mwa_adapter_tb.sv
module mwa_adapter_tb;
  localparam int MEM_N = 'h204;
  localparam int NV    = 36;
  localparam int VW    = 1 + 2 + 16 + 32 + 32 + 1 + 3 + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [15:0] cpu_addr = 16'd0;
  logic [31:0] cpu_wdata = 32'd0;
  logic        cpu_ready, cpu_err;
  logic [31:0] cpu_rdata;
  logic        reg_valid, reg_write, reg_ready;
  logic [1:0]  reg_size;
  logic [9:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int unsigned cyc = 0;
  int unsigned nat_total = 0;
  int unsigned last_ack = 0;
  logic [7:0]  mem [MEM_N];
  logic [9:0]  log_addr [16];
  logic [1:0]  log_sz [16];
  logic        log_wr [16];
  logic [31:0] log_wd [16];
  bit          hung = 1'b0;
  int          n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  mwa_adapter u_dut (
    .clk (clk), .rst_n (rst_n),
    .cpu_valid (cpu_valid), .cpu_ready (cpu_ready), .cpu_write (cpu_write),
    .cpu_size (cpu_size), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata), .cpu_err (cpu_err),
    .reg_valid (reg_valid), .reg_ready (reg_ready), .reg_write (reg_write),
    .reg_size (reg_size), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // register model: stalls one cycle in three, big-endian byte store
  assign reg_ready = (cyc % 3) != 0;

  always_comb begin
    reg_rdata = 32'd0;
    for (int k = 0; k < 4; k++)
      if (k < (1 << reg_size) && (int'(reg_addr) + k) < MEM_N)
        reg_rdata = (reg_rdata << 8) | 32'(mem[int'(reg_addr) + k]);
  end

  initial for (int i = 0; i < MEM_N; i++) mem[i] = 8'(i);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_valid && reg_ready) begin
      log_addr[nat_total % 16] <= reg_addr;
      log_sz[nat_total % 16]   <= reg_size;
      log_wr[nat_total % 16]   <= reg_write;
      log_wd[nat_total % 16]   <= reg_wdata;
      nat_total <= nat_total + 1;
      last_ack  <= cyc;
      if (reg_write)
        for (int k = 0; k < 4; k++)
          if (k < (1 << reg_size))
            mem[int'(reg_addr) + k] <= reg_wdata[8*((1 << reg_size) - 1 - k) +: 8];
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    hung = 1'b1;
  end

  function automatic logic [VW-1:0] mk(input bit wr, input bit [1:0] sz, input bit [15:0] a,
      input bit [31:0] wd, input bit [31:0] rd, input bit er, input bit [2:0] n, input bit [3:0] rq);
    return {wr, sz, a, wd, rd, er, n, rq};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    mk(0, 0, 16'h0005, 0, 32'h05,       0, 1, 9),  // R9
    mk(0, 1, 16'h0030, 0, 32'h3031,     0, 1, 9),  // R9
    mk(0, 2, 16'h0044, 0, 32'h44454647, 0, 1, 9),  // R9
    mk(0, 0, 16'h0033, 0, 32'h33,       0, 1, 4),  // R4
    mk(0, 0, 16'h0032, 0, 32'h32,       0, 1, 4),  // R4
    mk(0, 0, 16'h0046, 0, 32'h46,       0, 1, 4),  // R4
    mk(0, 1, 16'h0046, 0, 32'h4647,     0, 1, 5),  // R5
    mk(0, 1, 16'h0044, 0, 32'h4445,     0, 1, 5),  // R5
    mk(0, 1, 16'h0010, 0, 32'h1011,     0, 2, 6),  // R6
    mk(0, 2, 16'h0020, 0, 32'h20212223, 0, 4, 7),  // R7
    mk(0, 2, 16'h0040, 0, 32'h40414243, 0, 2, 7),  // R7
    mk(0, 0, 16'hFC05, 0, 32'h05,       0, 1, 1),  // R1
    mk(0, 0, 16'h8046, 0, 32'h46,       0, 1, 1),  // R1
    mk(0, 1, 16'h0031, 0, 32'h3031,     0, 1, 11), // R11
    mk(0, 2, 16'h0047, 0, 32'h44454647, 0, 1, 11), // R11
    mk(0, 0, 16'h0200, 0, 32'h00,       0, 1, 2),  // R2 boundary
    mk(0, 0, 16'h0201, 0, 32'h0,        1, 0, 2),  // R2
    mk(0, 2, 16'h0200, 0, 32'h0,        1, 0, 2),  // R2 span
    mk(0, 0, 16'h00C4, 0, 32'h0,        1, 0, 3),  // R3
    mk(0, 3, 16'h0005, 0, 32'h0,        1, 0, 2),  // R2 size 3
    mk(1, 0, 16'h0033, 32'hA5, 0,       0, 2, 8),  // R8
    mk(0, 1, 16'h0032, 0, 32'h32A5,     0, 1, 8),  // R8
    mk(1, 1, 16'h0050, 32'hBEEF, 0,     0, 2, 8),  // R8
    mk(1, 0, 16'h0052, 32'h77, 0,       0, 2, 8),  // R8
    mk(0, 2, 16'h0050, 0, 32'hBEEF7753, 0, 1, 8),  // R8
    mk(1, 1, 16'h0014, 32'hCAFE, 0,     0, 2, 6),  // R6
    mk(0, 0, 16'h0014, 0, 32'hCA,       0, 1, 6),  // R6
    mk(0, 0, 16'h0015, 0, 32'hFE,       0, 1, 6),  // R6
    mk(1, 2, 16'h0100, 32'h11223344, 0, 0, 4, 7),  // R7
    mk(0, 1, 16'h0102, 0, 32'h3344,     0, 2, 7),  // R7
    mk(1, 2, 16'h0038, 32'hDEADBEEF, 0, 0, 2, 7),  // R7
    mk(0, 0, 16'h0038, 0, 32'hDE,       0, 1, 7),  // R7
    mk(0, 0, 16'h003B, 0, 32'hEF,       0, 1, 7),  // R7
    mk(1, 0, 16'h00C8, 32'hFF, 0,       1, 0, 3),  // R3
    mk(1, 0, 16'h0201, 32'h99, 0,       1, 0, 2),  // R2
    mk(0, 1, 16'hFD00, 0, 32'h1122,     0, 2, 1)   // R1
  };

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [15:0] a,
      input logic [31:0] wd, output logic [31:0] rd, output logic er, output int n,
      output int unsigned rcyc, output int unsigned start);
    start = nat_total;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
    do @(negedge clk); while (!cpu_ready && !hung);
    rd = cpu_rdata; er = cpu_err; rcyc = cyc;
    @(posedge clk); #1;
    cpu_valid = 1'b0;
    n = int'(nat_total - start);
  endtask

  initial begin
    logic [31:0] rd;
    logic er;
    int n;
    int unsigned rc, st;
    string tag;

    repeat (3) @(negedge clk);
    cmp("R12", "cpu_ready in reset", 32'(cpu_ready), 0);
    cmp("R12", "reg_valid in reset", 32'(reg_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R12", "cpu_ready after reset", 32'(cpu_ready), 0);
    cmp("R12", "reg_valid after reset", 32'(reg_valid), 0);

    for (int i = 0; i < NV && !hung; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      access(v[90], v[89:88], v[87:72], v[71:40], rd, er, n, rc, st);
      cmp(tag, "err", 32'(er), 32'(v[7]));
      cmp(tag, "native count", 32'(n), 32'(v[6:4]));
      if (!v[90]) cmp(tag, "rdata", rd, v[39:8]);
    end

    // R6: split order and lane placement of a halfword write to a byte group
    access(1, 1, 16'h0018, 32'h1234, rd, er, n, rc, st);
    cmp("R6", "part0 addr", 32'(log_addr[st % 16]), 32'h18);
    cmp("R6", "part0 data", log_wd[st % 16], 32'h12);
    cmp("R6", "part1 addr", 32'(log_addr[(st + 1) % 16]), 32'h19);
    cmp("R6", "part1 data", log_wd[(st + 1) % 16], 32'h34);
    cmp("R10", "done after last handshake", rc, last_ack + 1);

    // R8: read then merged write for a byte written into a word register
    access(1, 0, 16'h0045, 32'h9C, rd, er, n, rc, st);
    cmp("R8", "first is read", 32'(log_wr[st % 16]), 0);
    cmp("R8", "read size word", 32'(log_sz[st % 16]), 2);
    cmp("R8", "read addr", 32'(log_addr[st % 16]), 32'h44);
    cmp("R8", "second is write", 32'(log_wr[(st + 1) % 16]), 1);
    cmp("R8", "merged data", log_wd[(st + 1) % 16], 32'h449C4647);
    cmp("R10", "done after merge write", rc, last_ack + 1);
    access(0, 2, 16'h0044, 0, rd, er, n, rc, st);
    cmp("R8", "word after merge", rd, 32'h449C4647);

    // R7: four byte parts for a word read of a byte group, ascending
    access(0, 2, 16'h0024, 0, rd, er, n, rc, st);
    cmp("R7", "word from bytes", rd, 32'h24252627);
    for (int k = 0; k < 4; k++)
      cmp("R7", "part addr", 32'(log_addr[(st + k) % 16]), 32'h24 + k);
    cmp("R10", "done after fourth part", rc, last_ack + 1);

    if (hung) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule